// File: doc/BRIEF.md
# Plug-and-Play Card State Controller

This block is the card-level control core of an auto-configuring expansion card on an ISA-style I/O bus. It watches decoded 8-bit bus writes to two fixed, write-only I/O ports. The first is an index port that selects a configuration register. The second is a data port that writes the selected register. From these writes it tracks the card's configuration state and holds the card-wide settings that host software assigns.

The card has four states: waiting for the initiation key, sleep, isolation and configuration. An external key detector supplies a one-cycle pulse once the key sequence has been recognised. That pulse takes the card out of the key-wait state. After that, wake commands, control commands and plain register writes move the card between states and load its card select number, read-data port location and logical device number.

A combinational readback gives the value of the currently indexed register. Two one-cycle pulses tell neighbouring logic to restore the logical device defaults and to rewind the serial identifier pointer.

Top module: `pnp_card_ctrl`

## Requirements
- R1: While rst_ni is low, and after it is released, state_o is 0 (key-wait), csn_o is 0, ldn_o is 0, rd_port_o is 0, reg_sel_o is 0, and both pulses are low. State codes are: 0 key-wait, 1 sleep, 2 isolation, 3 configuration.
- R2: A key_hit_i pulse in key-wait moves state_o to 1 on the next edge. In any other state the pulse has no effect.
- R3: While in key-wait, writes to the data port change no register and no state.
- R4: A write to the index port (address 0x0279) loads reg_sel_o with the written byte. The selection then stays in place for any number of data-port writes (address 0x0A79) until the index port is written again. Writes to other addresses do nothing.
- R5: A data write to index 0x00 sets rd_port_o to {data, 2'b11}, so data 0x80 gives 0x203. This happens only in isolation; in sleep or configuration such a write leaves rd_port_o unchanged.
- R6: In sleep, a data write to index 0x03 whose byte equals csn_o moves the card to isolation if the byte is 0, and to configuration otherwise. It also raises sid_rst_o for one cycle. A byte that differs from csn_o has no effect.
- R7: A data write to index 0x02 with bit 2 set clears csn_o and rd_port_o to 0.
- R8: A data write to index 0x02 with bit 1 set returns the card to key-wait and leaves csn_o unchanged.
- R9: A data write to index 0x02 with bit 0 set raises cfg_rst_o for one cycle. State and csn_o are unchanged.
- R10: Control commands self-clear. Each command acts once per write, its pulse drops on the following cycle with no further write, and index 0x02 reads back as 0.
- R11: Index 0x06 writes csn_o and index 0x07 writes ldn_o. When either index is selected, reg_rdata_o shows that register.
- R12: Every selected index other than 0x06 and 0x07 reads back as 0 on reg_rdata_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | One-cycle decoded I/O write strobe |
| bus_addr_i | input | 16 | I/O write address |
| bus_data_i | input | 8 | I/O write data |
| key_hit_i | input | 1 | One-cycle pulse from the initiation key detector |
| state_o | output | 2 | Card state (0 key-wait, 1 sleep, 2 isolation, 3 configuration) |
| csn_o | output | 8 | Card select number |
| ldn_o | output | 8 | Logical device number |
| rd_port_o | output | 10 | Read-data port I/O address |
| reg_sel_o | output | 8 | Currently indexed register |
| reg_rdata_o | output | 8 | Readback of the indexed register |
| cfg_rst_o | output | 1 | Pulse: restore logical device defaults |
| sid_rst_o | output | 1 | Pulse: rewind serial identifier pointer |

## Verification
The bench drives the index port once and then makes repeated data writes, so it can catch a design that forgets the selection or re-latches it from the data port. It issues wake commands with a matching byte and with a mismatched byte, and with zero and non-zero bytes. A design that compares against the wrong value, or that swaps the isolation and configuration targets, ends in the wrong state. It tries read-data port writes in sleep, isolation and configuration, which exposes any state gating that is missing. It sends key pulses, data writes and control commands while the card is in key-wait or sleep. A design that does not gate these leaks register or state changes. The control commands are checked for pulses that stick high and for a card select number that is lost or kept when it should not be.

// File: rtl/pnp_card_pkg.sv
package pnp_card_pkg;
  typedef enum logic [1:0] {
    ST_WAIT_KEY = 2'd0,
    ST_SLEEP    = 2'd1,
    ST_ISOLATE  = 2'd2,
    ST_CONFIG   = 2'd3
  } card_state_e;

  localparam logic [7:0] IDX_RDPORT = 8'h00;
  localparam logic [7:0] IDX_CTRL   = 8'h02;
  localparam logic [7:0] IDX_WAKE   = 8'h03;
  localparam logic [7:0] IDX_CSN    = 8'h06;
  localparam logic [7:0] IDX_LDN    = 8'h07;

  localparam int CMD_DEFAULTS = 0;
  localparam int CMD_TO_WAIT  = 1;
  localparam int CMD_CLR_CSN  = 2;
endpackage

// File: rtl/pnp_port_dec.sv
module pnp_port_dec #(
  parameter int          ADDR_W     = 16,
  parameter logic [15:0] ADDR_PORT  = 16'h0279,
  parameter logic [15:0] WDATA_PORT = 16'h0A79
) (
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              idx_wr_o,
  output logic              dat_wr_o
);
  localparam logic [ADDR_W-1:0] IDX_A = ADDR_W'(ADDR_PORT);
  localparam logic [ADDR_W-1:0] DAT_A = ADDR_W'(WDATA_PORT);

  assign idx_wr_o = wr_i && (addr_i == IDX_A);
  assign dat_wr_o = wr_i && (addr_i == DAT_A);

  always_comb begin
    assert (!(idx_wr_o && dat_wr_o)); // R4
  end
endmodule

// File: rtl/pnp_card_fsm.sv
module pnp_card_fsm
  import pnp_card_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        key_hit_i,
  input  logic        wake_hit_i,
  input  logic        wake_zero_i,
  input  logic        cmd_wait_i,
  output card_state_e state_o,
  output logic        sid_rst_o
);
  card_state_e state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_WAIT_KEY;
      sid_rst_o <= 1'b0;
    end else begin
      sid_rst_o <= wake_hit_i;
      if (cmd_wait_i) begin
        state_q <= ST_WAIT_KEY;
      end else begin
        unique case (state_q)
          ST_WAIT_KEY: if (key_hit_i) state_q <= ST_SLEEP;
          ST_SLEEP:    if (wake_hit_i) state_q <= wake_zero_i ? ST_ISOLATE : ST_CONFIG;
          default:     ;
        endcase
      end
    end
  end

  assign state_o = state_q;

  AST_KEY_TO_SLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT_KEY && key_hit_i) |=> state_q == ST_SLEEP); // R2
  AST_WAIT_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT_KEY) |=> (state_q == ST_WAIT_KEY || state_q == ST_SLEEP)); // R2
  AST_WAKE_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sid_rst_o |-> (state_q == ST_ISOLATE || state_q == ST_CONFIG)); // R6
endmodule

// File: rtl/pnp_card_regs.sv
module pnp_card_regs
  import pnp_card_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int RDP_W = DATA_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              idx_wr_i,
  input  logic              dat_wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  card_state_e       state_i,
  output logic [DATA_W-1:0] sel_o,
  output logic [DATA_W-1:0] csn_o,
  output logic [DATA_W-1:0] ldn_o,
  output logic [RDP_W-1:0]  rd_port_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              cfg_rst_o,
  output logic              wake_hit_o,
  output logic              wake_zero_o,
  output logic              cmd_wait_o
);
  logic [DATA_W-1:0] sel_q, csn_q, ldn_q;
  logic [RDP_W-1:0]  rdp_q;
  logic wr_ok, hit_ctrl, hit_rdp, hit_csn, hit_ldn, hit_wake;

  assign wr_ok    = dat_wr_i && (state_i != ST_WAIT_KEY);
  assign hit_ctrl = wr_ok && (sel_q == DATA_W'(IDX_CTRL));
  assign hit_rdp  = wr_ok && (sel_q == DATA_W'(IDX_RDPORT));
  assign hit_csn  = wr_ok && (sel_q == DATA_W'(IDX_CSN));
  assign hit_ldn  = wr_ok && (sel_q == DATA_W'(IDX_LDN));
  assign hit_wake = wr_ok && (sel_q == DATA_W'(IDX_WAKE));

  assign wake_hit_o  = hit_wake && (state_i == ST_SLEEP) && (data_i == csn_q);
  assign wake_zero_o = (data_i == '0);
  assign cmd_wait_o  = hit_ctrl && data_i[CMD_TO_WAIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q     <= '0;
      csn_q     <= '0;
      ldn_q     <= '0;
      rdp_q     <= '0;
      cfg_rst_o <= 1'b0;
    end else begin
      cfg_rst_o <= hit_ctrl && data_i[CMD_DEFAULTS];
      if (idx_wr_i) sel_q <= data_i;
      if (hit_ctrl && data_i[CMD_CLR_CSN]) begin
        csn_q <= '0;
        rdp_q <= '0;
      end else begin
        if (hit_csn) csn_q <= data_i;
        if (hit_rdp && state_i == ST_ISOLATE) rdp_q <= {data_i, 2'b11};
      end
      if (hit_ldn) ldn_q <= data_i;
    end
  end

  // only two indices are readable; the rest read as zero
  always_comb begin
    if (sel_q == DATA_W'(IDX_CSN))      rdata_o = csn_q;
    else if (sel_q == DATA_W'(IDX_LDN)) rdata_o = ldn_q;
    else                                rdata_o = '0;
  end

  assign sel_o     = sel_q;
  assign csn_o     = csn_q;
  assign ldn_o     = ldn_q;
  assign rd_port_o = rdp_q;

  AST_WAIT_IGNORES_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_WAIT_KEY && dat_wr_i) |=> ($stable(csn_q) && $stable(ldn_q) && $stable(rdp_q))); // R3
  AST_RDP_ONLY_ISOLATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(rdp_q) && rdp_q != '0) |-> $past(state_i) == ST_ISOLATE); // R5
  AST_SEL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idx_wr_i |=> $stable(sel_q)); // R4
  AST_CFG_FROM_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rst_o |-> $past(dat_wr_i)); // R9
endmodule

// File: rtl/pnp_card_ctrl.sv
module pnp_card_ctrl
  import pnp_card_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int          DATA_W     = 8,
  parameter logic [15:0] ADDR_PORT  = 16'h0279,
  parameter logic [15:0] WDATA_PORT = 16'h0A79,
  localparam int         RDP_W      = DATA_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic              key_hit_i,
  output logic [1:0]        state_o,
  output logic [DATA_W-1:0] csn_o,
  output logic [DATA_W-1:0] ldn_o,
  output logic [RDP_W-1:0]  rd_port_o,
  output logic [DATA_W-1:0] reg_sel_o,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              cfg_rst_o,
  output logic              sid_rst_o
);
  logic        idx_wr, dat_wr, wake_hit, wake_zero, cmd_wait;
  card_state_e state;

  pnp_port_dec #(
    .ADDR_W(ADDR_W), .ADDR_PORT(ADDR_PORT), .WDATA_PORT(WDATA_PORT)
  ) u_dec (
    .wr_i(bus_wr_i), .addr_i(bus_addr_i), .idx_wr_o(idx_wr), .dat_wr_o(dat_wr)
  );

  pnp_card_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .idx_wr_i(idx_wr), .dat_wr_i(dat_wr),
    .data_i(bus_data_i), .state_i(state), .sel_o(reg_sel_o), .csn_o(csn_o),
    .ldn_o(ldn_o), .rd_port_o(rd_port_o), .rdata_o(reg_rdata_o),
    .cfg_rst_o(cfg_rst_o), .wake_hit_o(wake_hit), .wake_zero_o(wake_zero),
    .cmd_wait_o(cmd_wait)
  );

  pnp_card_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .key_hit_i(key_hit_i), .wake_hit_i(wake_hit),
    .wake_zero_i(wake_zero), .cmd_wait_i(cmd_wait), .state_o(state),
    .sid_rst_o(sid_rst_o)
  );

  assign state_o = state;

  AST_CFG_PULSE_KEEPS_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rst_o |-> (state_o != 2'd0 || $past(state_o) == 2'd0 || $past(cmd_wait))); // R9
endmodule

// File: tb/pnp_card_ctrl_tb.sv
module pnp_card_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0] data = '0;
  logic       key = 1'b0;
  logic [1:0] state;
  logic [7:0] csn, ldn, sel, rdata;
  logic [9:0] rdp;
  logic       cfg_rst, sid_rst;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pnp_card_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_data_i(data), .key_hit_i(key), .state_o(state), .csn_o(csn),
    .ldn_o(ldn), .rd_port_o(rdp), .reg_sel_o(sel), .reg_rdata_o(rdata),
    .cfg_rst_o(cfg_rst), .sid_rst_o(sid_rst)
  );

  // behavioural reference
  int m_state, m_csn, m_ldn, m_rdp, m_sel, m_cfg, m_sid;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_csn = 0; m_ldn = 0; m_rdp = 0; m_sel = 0; m_cfg = 0; m_sid = 0;
    end else begin
      int ns;
      ns = m_state; m_cfg = 0; m_sid = 0;
      if (wr && addr == 16'h0279) m_sel = data;
      else if (wr && addr == 16'h0A79 && m_state != 0) begin
        case (m_sel)
          0: if (m_state == 2) m_rdp = data * 4 + 3;
          2: begin
            if (data[2]) begin m_csn = 0; m_rdp = 0; end
            if (data[1]) ns = 0;
            if (data[0]) m_cfg = 1;
          end
          3: if (m_state == 1 && data == m_csn) begin
            ns = (data == 0) ? 2 : 3; m_sid = 1;
          end
          6: m_csn = data;
          7: m_ldn = data;
          default: ;
        endcase
      end
      if (key && m_state == 0) ns = 1;
      m_state = ns;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R2 state", state, m_state);
    chk("R11 csn", csn, m_csn);
    chk("R11 ldn", ldn, m_ldn);
    chk("R5 rd_port", rdp, m_rdp);
    chk("R4 sel", sel, m_sel);
    chk("R12 rdata", rdata, (m_sel == 6) ? m_csn : (m_sel == 7) ? m_ldn : 0);
    chk("R9 cfg_rst", cfg_rst, m_cfg);
    chk("R6 sid_rst", sid_rst, m_sid);
  end

  task automatic bus(input logic [15:0] a, input logic [7:0] d);
    @(posedge clk); #2; wr = 1'b1; addr = a; data = d;
    @(posedge clk); #2; wr = 1'b0; addr = '0; data = '0;
  endtask
  task automatic idx(input logic [7:0] d); bus(16'h0279, d); endtask
  task automatic wd(input logic [7:0] d);  bus(16'h0A79, d); endtask
  task automatic pulse_key();
    @(posedge clk); #2; key = 1'b1;
    @(posedge clk); #2; key = 1'b0;
  endtask

  initial begin
    #2;
    chk("R1 state in reset", state, 0);
    chk("R1 csn in reset", csn, 0);
    chk("R1 rdp in reset", rdp, 0);
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(posedge clk); #2;
    chk("R1 state", state, 0); chk("R1 sel", sel, 0); chk("R1 ldn", ldn, 0);
    // R3: data writes in key-wait ignored
    idx(8'h06); chk("R4 sel=6", sel, 8'h06);
    wd(8'h55); chk("R3 csn", csn, 0); chk("R3 state", state, 0);
    idx(8'h02); wd(8'h01); chk("R3 cfg_rst", cfg_rst, 0);
    // R2
    pulse_key(); chk("R2 to sleep", state, 1);
    pulse_key(); chk("R2 key ignored in sleep", state, 1);
    // R5 in sleep
    idx(8'h00); wd(8'h80); chk("R5 sleep ignore", rdp, 0);
    // R6 mismatch, then match zero
    idx(8'h03); wd(8'h01); chk("R6 mismatch", state, 1); chk("R6 no pulse", sid_rst, 0);
    wd(8'h00); chk("R6 to isolation", state, 2); chk("R6 sid pulse", sid_rst, 1);
    @(posedge clk); #2; chk("R6 sid drops", sid_rst, 0);
    // R5 in isolation, R4 repeated access
    idx(8'h00); wd(8'h80); chk("R5 rdp 0x203", rdp, 10'h203);
    wd(8'hFF); chk("R4 repeat rdp 0x3FF", rdp, 10'h3FF);
    bus(16'h1234, 8'h07); chk("R4 foreign addr", sel, 8'h00);
    // R11
    idx(8'h06); wd(8'h05); chk("R11 csn", csn, 5); chk("R11 rdata csn", rdata, 5);
    idx(8'h07); wd(8'h02); chk("R11 ldn", ldn, 2); chk("R11 rdata ldn", rdata, 2);
    // R12 / R10
    idx(8'h04); chk("R12 rdata 0", rdata, 0);
    idx(8'h02); chk("R10 ctrl reads 0", rdata, 0);
    // R9 / R10
    wd(8'h01); chk("R9 cfg pulse", cfg_rst, 1); chk("R9 state", state, 2); chk("R9 csn", csn, 5);
    @(posedge clk); #2; chk("R10 cfg self-clear", cfg_rst, 0);
    // R8
    wd(8'h02); chk("R8 to wait", state, 0); chk("R8 csn kept", csn, 5);
    // R6 to config
    pulse_key(); idx(8'h03); wd(8'h05);
    chk("R6 to config", state, 3); chk("R6 sid pulse cfg", sid_rst, 1);
    // R5 in config
    idx(8'h00); wd(8'h10); chk("R5 config ignore", rdp, 10'h3FF);
    // R7
    idx(8'h02); wd(8'h04);
    chk("R7 csn clr", csn, 0); chk("R7 rdp clr", rdp, 0); chk("R7 state", state, 3);
    // R1 async reset mid-run
    @(negedge clk); rst_n = 1'b0; #1;
    chk("R1 state async", state, 0); chk("R1 ldn async", ldn, 0); chk("R1 sel async", sel, 0);
    @(posedge clk); #2 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #2;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule